// File: doc/BRIEF.md
# Page-bounded NOR program sequencer

This block writes a byte stream of any length into a serial NOR flash whose target region is already erased. Software or an upstream engine gives a start offset, a byte count, the device page size (as a base-2 logarithm) and the address width. It then feeds the data bytes on a valid/ready stream. The sequencer cuts the stream into page program commands, and no command runs past the end of a page. It clamps the page to a power-of-two write limit set at build time. Before each program command it checks the device status and sets write enable. It waits for the device to go idle at the end.

The flash side is a byte link, one byte per valid/ready handshake. A byte flagged `read` is a read slot. Its returned status byte is taken from `link_rdata_i` in the same handshake. `link_last_o` marks the final byte of a chip-select frame. A lower serializer turns frames into SPI bit traffic.

Top module: `nor_page_prog`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `link_valid_o` and `in_ready_o` are 0. While `busy_o` is 0, no link byte is offered and no stream byte is taken.
- R2: The effective page is 2^min(`page_log2_i`, MAX_WR_LOG2) bytes. With the default MAX_WR_LOG2 = 6, any larger device page behaves as a 64-byte page.
- R3: Each chunk is min(remaining, page − (offset & (page − 1))) bytes and never crosses an effective page boundary. After each chunk the offset advances by the chunk length, and the remaining count drops by the same amount.
- R4: A busy wait is a repeated status frame: byte 0x05, then one read slot that ends the frame. The wait repeats while status bit 0 (busy) is 1. One wait comes before every chunk and one after the last chunk.
- R5: After the pre-chunk wait, a one-byte frame 0x06 (write enable) is sent, followed by one status frame. If status bit 1 is 0 in that frame, the operation ends with `err_o` = 2 and no program frame is sent.
- R6: A program frame is 0x02, then the offset most significant byte first, then the chunk's data bytes in stream order. The offset is 4 bytes when `addr4_i` = 1 and the low 3 bytes otherwise. The last data byte carries `link_last_o`. Prefix bytes hold steady while the link stalls.
- R7: When the final wait finds the device idle, `done_o` pulses for one cycle with `err_o` = 0. A zero length does only the final wait. `err_o` holds its value until the next start.
- R8: If a wait reads busy POLL_LIMIT times in a row (default 8), the operation ends with `err_o` = 1 and sends no further frames. POLL_LIMIT − 1 busy reads followed by an idle read is not a timeout.
- R9: `in_ready_o` is high only during the data part of a program frame. Stream bytes are never taken during prefix bytes or status polling, so the stream drains exactly `len_i` bytes on success and none on an early error.
- R10: No frame is longer than MSG_LIMIT bytes. Elaboration fails if 5 + 2^MAX_WR_LOG2 exceeds MSG_LIMIT.
- R11: `start_i` is ignored while `busy_o` is 1. Offset, length, page size and address mode are captured only when the block starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| offset_i | input | 32 | Flash byte offset of the first data byte |
| len_i | input | LEN_W | Number of bytes to write |
| page_log2_i | input | PG_W | Base-2 log of the device page size |
| addr4_i | input | 1 | 1: 4-byte addresses, 0: 3-byte addresses |
| in_valid_i | input | 1 | Data stream byte valid |
| in_data_i | input | 8 | Data stream byte |
| in_ready_o | output | 1 | Data stream byte taken |
| link_valid_o | output | 1 | Link byte offered |
| link_data_o | output | 8 | Link byte to send |
| link_read_o | output | 1 | This byte is a read slot |
| link_last_o | output | 1 | Last byte of the current frame |
| link_ready_i | input | 1 | Link accepts the byte |
| link_rdata_i | input | 8 | Status byte returned in a read slot |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| err_o | output | 2 | 0 ok, 1 busy timeout, 2 write enable not set |

## Verification
Directed offsets are chosen to sit just short of a page end, in both address modes. They separate the first short chunk from the full-page chunks that follow, and show whether the clamp to the write limit applies. Random runs draw the offset, the length and the page exponent, including a one-byte page. They also stall the link and the stream at random and vary the busy count per wait. These runs catch errors in the chunk arithmetic, the address order and data taken at the wrong moment. Busy counts of exactly POLL_LIMIT − 1 and POLL_LIMIT separate a long but valid wait from a timeout. A device that refuses write enable, a zero length and a start pulse during an operation check the early exits and start capture.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_WEL     = 2'd2
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_WREN, S_WEL, S_OPC, S_ADDR, S_DATA, S_FINAL, S_END
  } seq_e;

  typedef enum logic [1:0] {
    P_IDLE, P_OP, P_RD, P_DONE
  } poll_e;

endpackage

// File: rtl/nor_chunk_calc.sv
module nor_chunk_calc #(
  parameter int LEN_W       = 16,
  parameter int PG_W        = 5,
  parameter int MAX_WR_LOG2 = 6,
  localparam int CHUNK_W    = MAX_WR_LOG2 + 1,
  localparam int EL_W       = $clog2(MAX_WR_LOG2 + 1)
) (
  input  logic [CHUNK_W-1:0] off_lo_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [PG_W-1:0]    pg_log2_i,
  output logic [EL_W-1:0]    eff_log2_o,
  output logic [CHUNK_W-1:0] chunk_o
);

  logic [CHUNK_W-1:0] eff, mask, in_page, room;

  always_comb begin
    if (pg_log2_i > PG_W'(MAX_WR_LOG2)) eff_log2_o = EL_W'(MAX_WR_LOG2);
    else                                eff_log2_o = pg_log2_i[EL_W-1:0];
    eff     = CHUNK_W'(1) << eff_log2_o;
    mask    = eff - CHUNK_W'(1);
    in_page = off_lo_i & mask;
    room    = eff - in_page;
    if (rem_i < LEN_W'(room)) chunk_o = rem_i[CHUNK_W-1:0];
    else                      chunk_o = room;
  end

endmodule

// File: rtl/nor_status_poll.sv
module nor_status_poll
  import nor_prog_pkg::*;
#(
  parameter int POLL_LIMIT = 8,
  localparam int CNT_W     = $clog2(POLL_LIMIT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       wait_mode_i,  // 1: wait for idle, 0: single write-enable check
  input  logic       ready_i,
  input  logic [7:0] rdata_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       read_o,
  output logic       last_o,
  output logic       done_o,
  output logic       fail_o
);

  poll_e            st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q;
  logic             unused_rdata;

  assign unused_rdata = ^rdata_i[7:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_IDLE;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        P_IDLE: if (req_i) begin
          st_q   <= P_OP;
          cnt_q  <= '0;
          fail_q <= 1'b0;
        end
        P_OP: if (ready_i) st_q <= P_RD;
        P_RD: if (ready_i) begin
          if (!wait_mode_i) begin
            fail_q <= !rdata_i[WEL_BIT];
            st_q   <= P_DONE;
          end else if (!rdata_i[BUSY_BIT]) begin
            st_q <= P_DONE;
          end else if (cnt_q == CNT_W'(POLL_LIMIT - 1)) begin
            fail_q <= 1'b1;
            st_q   <= P_DONE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            st_q  <= P_OP;
          end
        end
        P_DONE: st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign valid_o = (st_q == P_OP) || (st_q == P_RD);
  assign data_o  = (st_q == P_OP) ? OP_RDSR : 8'h00;
  assign read_o  = (st_q == P_RD);
  assign last_o  = (st_q == P_RD);
  assign done_o  = (st_q == P_DONE);
  assign fail_o  = fail_q;

endmodule

// File: rtl/nor_page_prog.sv
module nor_page_prog
  import nor_prog_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int PG_W        = 5,
  parameter int MAX_WR_LOG2 = 6,
  parameter int MSG_LIMIT   = 72,
  parameter int POLL_LIMIT  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      offset_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PG_W-1:0]  page_log2_i,
  input  logic             addr4_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             link_valid_o,
  output logic [7:0]       link_data_o,
  output logic             link_read_o,
  output logic             link_last_o,
  input  logic             link_ready_i,
  input  logic [7:0]       link_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o
);

  localparam int CHUNK_W    = MAX_WR_LOG2 + 1;
  localparam int EL_W       = $clog2(MAX_WR_LOG2 + 1);
  localparam int PREFIX_MAX = 5;

  if (PREFIX_MAX + (1 << MAX_WR_LOG2) > MSG_LIMIT) begin : g_limit_bad
    $error("program frame would exceed MSG_LIMIT");
  end

  seq_e               state_q;
  logic [31:0]        off_q;
  logic [LEN_W-1:0]   rem_q;
  logic [PG_W-1:0]    pg_q;
  logic               a4_q;
  logic [1:0]         idx_q;
  logic [CHUNK_W-1:0] dcnt_q;
  err_e               err_q;

  logic [CHUNK_W-1:0] off_lo;
  logic [CHUNK_W-1:0] chunk_len;
  logic [EL_W-1:0]    eff_log2;
  logic [7:0]         addr_byte;
  logic               data_last;

  logic       p_req, p_mode, p_valid, p_read, p_last, p_done, p_fail;
  logic [7:0] p_data;

  assign off_lo = off_q[CHUNK_W-1:0];

  nor_chunk_calc #(
    .LEN_W(LEN_W), .PG_W(PG_W), .MAX_WR_LOG2(MAX_WR_LOG2)
  ) u_calc (
    .off_lo_i   (off_lo),
    .rem_i      (rem_q),
    .pg_log2_i  (pg_q),
    .eff_log2_o (eff_log2),
    .chunk_o    (chunk_len)
  );

  assign p_req  = (state_q == S_WAIT) || (state_q == S_WEL) || (state_q == S_FINAL);
  assign p_mode = (state_q != S_WEL);

  nor_status_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (p_req),
    .wait_mode_i (p_mode),
    .ready_i     (link_ready_i),
    .rdata_i     (link_rdata_i),
    .valid_o     (p_valid),
    .data_o      (p_data),
    .read_o      (p_read),
    .last_o      (p_last),
    .done_o      (p_done),
    .fail_o      (p_fail)
  );

  always_comb begin
    unique case (idx_q)
      2'd0:    addr_byte = off_q[31:24];
      2'd1:    addr_byte = off_q[23:16];
      2'd2:    addr_byte = off_q[15:8];
      default: addr_byte = off_q[7:0];
    endcase
  end

  assign data_last = (dcnt_q == chunk_len - CHUNK_W'(1));

  always_comb begin
    link_valid_o = 1'b0;
    link_data_o  = 8'h00;
    link_read_o  = 1'b0;
    link_last_o  = 1'b0;
    in_ready_o   = 1'b0;
    unique case (state_q)
      S_WAIT, S_WEL, S_FINAL: begin
        link_valid_o = p_valid;
        link_data_o  = p_data;
        link_read_o  = p_read;
        link_last_o  = p_last;
      end
      S_WREN: begin
        link_valid_o = 1'b1;
        link_data_o  = OP_WREN;
        link_last_o  = 1'b1;
      end
      S_OPC: begin
        link_valid_o = 1'b1;
        link_data_o  = OP_PROG;
      end
      S_ADDR: begin
        link_valid_o = 1'b1;
        link_data_o  = addr_byte;
      end
      S_DATA: begin
        link_valid_o = in_valid_i;
        link_data_o  = in_data_i;
        link_last_o  = data_last;
        in_ready_o   = link_ready_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      off_q   <= '0;
      rem_q   <= '0;
      pg_q    <= '0;
      a4_q    <= 1'b0;
      idx_q   <= '0;
      dcnt_q  <= '0;
      err_q   <= ERR_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          off_q   <= offset_i;
          rem_q   <= len_i;
          pg_q    <= page_log2_i;
          a4_q    <= addr4_i;
          err_q   <= ERR_NONE;
          state_q <= (len_i == '0) ? S_FINAL : S_WAIT;
        end
        S_WAIT: if (p_done) begin
          if (p_fail) begin
            err_q   <= ERR_TIMEOUT;
            state_q <= S_END;
          end else begin
            state_q <= S_WREN;
          end
        end
        S_WREN: if (link_ready_i) state_q <= S_WEL;
        S_WEL: if (p_done) begin
          if (p_fail) begin
            err_q   <= ERR_WEL;
            state_q <= S_END;
          end else begin
            state_q <= S_OPC;
          end
        end
        S_OPC: if (link_ready_i) begin
          idx_q   <= a4_q ? 2'd0 : 2'd1;
          state_q <= S_ADDR;
        end
        S_ADDR: if (link_ready_i) begin
          if (idx_q == 2'd3) begin
            dcnt_q  <= '0;
            state_q <= S_DATA;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_DATA: if (in_valid_i && link_ready_i) begin
          if (data_last) begin
            off_q   <= off_q + 32'(chunk_len);
            rem_q   <= rem_q - LEN_W'(chunk_len);
            state_q <= (rem_q == LEN_W'(chunk_len)) ? S_FINAL : S_WAIT;
          end else begin
            dcnt_q <= dcnt_q + CHUNK_W'(1);
          end
        end
        S_FINAL: if (p_done) begin
          if (p_fail) err_q <= ERR_TIMEOUT;
          state_q <= S_END;
        end
        S_END: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_END);
  assign err_o  = err_q;

endmodule

// File: rtl/nor_page_prog_chk.sv
module nor_page_prog_chk
  import nor_prog_pkg::*;
#(
  parameter int MAX_WR_LOG2 = 6,
  parameter int MSG_LIMIT   = 72,
  localparam int CHUNK_W    = MAX_WR_LOG2 + 1,
  localparam int EL_W       = $clog2(MAX_WR_LOG2 + 1),
  localparam int FC_W       = $clog2(MSG_LIMIT + 1) + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [1:0]         err_o,
  input logic               in_ready_o,
  input logic               link_valid_o,
  input logic [7:0]         link_data_o,
  input logic               link_read_o,
  input logic               link_last_o,
  input logic               link_ready_i,
  input seq_e               state_q,
  input logic [CHUNK_W-1:0] chunk_len,
  input logic [CHUNK_W-1:0] off_lo,
  input logic [EL_W-1:0]    eff_log2
);

  logic [CHUNK_W-1:0] pg_bytes, pg_mask;
  logic [CHUNK_W:0]   span;
  logic [FC_W-1:0]    fbytes_q;
  logic               fire;

  assign pg_bytes = CHUNK_W'(1) << eff_log2;
  assign pg_mask  = pg_bytes - CHUNK_W'(1);
  assign span     = {1'b0, off_lo & pg_mask} + {1'b0, chunk_len};
  assign fire     = link_valid_o && link_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fbytes_q <= '0;
    else if (fire)        fbytes_q <= link_last_o ? '0 : fbytes_q + FC_W'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!link_valid_o && !in_ready_o)); // R1

  AST_READ_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_o && link_read_o) |-> link_last_o); // R4

  AST_PREFIX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_o && !link_ready_i && state_q != S_DATA)
      |=> (link_valid_o && $stable(link_data_o) && $stable(link_read_o))); // R6

  AST_STREAM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (link_ready_i && !link_read_o && busy_o)); // R9

  AST_CHUNK_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA) |-> (span <= {1'b0, pg_bytes})); // R3

  AST_CHUNK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA) |-> (chunk_len != '0)); // R3

  AST_FRAME_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (fbytes_q < FC_W'(MSG_LIMIT))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R7

  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(err_o)); // R7

endmodule

bind nor_page_prog nor_page_prog_chk #(
  .MAX_WR_LOG2(MAX_WR_LOG2),
  .MSG_LIMIT  (MSG_LIMIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .in_ready_o   (in_ready_o),
  .link_valid_o (link_valid_o),
  .link_data_o  (link_data_o),
  .link_read_o  (link_read_o),
  .link_last_o  (link_last_o),
  .link_ready_i (link_ready_i),
  .state_q      (state_q),
  .chunk_len    (chunk_len),
  .off_lo       (off_lo),
  .eff_log2     (eff_log2)
);

// File: tb/nor_page_prog_bench.sv
module nor_page_prog_bench;

  localparam int LEN_W = 16;
  localparam int PG_W  = 5;
  localparam int MAXL  = 6;
  localparam int MSG   = 72;
  localparam int PL    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [31:0]      offset_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [PG_W-1:0]  page_log2_i = '0;
  logic             addr4_i = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [7:0]       in_data_i = '0;
  logic             in_ready_o;
  logic             link_valid_o;
  logic [7:0]       link_data_o;
  logic             link_read_o;
  logic             link_last_o;
  logic             link_ready_i = 1'b0;
  logic [7:0]       link_rdata_i = '0;
  logic             busy_o, done_o;
  logic [1:0]       err_o;

  always #4 clk = ~clk;

  nor_page_prog #(
    .LEN_W(LEN_W), .PG_W(PG_W), .MAX_WR_LOG2(MAXL), .MSG_LIMIT(MSG), .POLL_LIMIT(PL)
  ) u_nor_page_prog (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .offset_i(offset_i),
    .len_i(len_i), .page_log2_i(page_log2_i), .addr4_i(addr4_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .link_valid_o(link_valid_o), .link_data_o(link_data_o),
    .link_read_o(link_read_o), .link_last_o(link_last_o),
    .link_ready_i(link_ready_i), .link_rdata_i(link_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] strm [1024];
  logic [7:0] fr [128];
  int  frame_len, feed_idx, sidx, n_prog, n_stat, busy_left, bpw, cfg_pg;
  bit  wel, wel_block, wren_seen, cfg_a4;
  logic [31:0] exp_off;
  int  exp_rem;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int calc_chunk(input logic [31:0] off, input int rem, input int pg);
    int e, eff, inpg, room;
    e    = (pg > MAXL) ? MAXL : pg;
    eff  = 1 << e;
    inpg = int'(off & 32'(eff - 1));
    room = eff - inpg;
    return (rem < room) ? rem : room;
  endfunction

  function automatic int count_chunks(input logic [31:0] off, input int len, input int pg);
    int n = 0;
    logic [31:0] o = off;
    int r = len;
    while (r > 0) begin
      int c = calc_chunk(o, r, pg);
      o = o + 32'(c);
      r = r - c;
      n++;
    end
    return n;
  endfunction

  task automatic process_frame();
    if (fr[0] == 8'h05) begin
      n_stat++;
      chk(frame_len == 2, "R4 status frame length", frame_len, 2);
    end else if (fr[0] == 8'h06) begin
      chk(frame_len == 1, "R5 write-enable frame length", frame_len, 1);
      wel = !wel_block;
      wren_seen = 1'b1;
    end else if (fr[0] == 8'h02) begin
      int c, alen;
      bit addr_ok, data_ok;
      n_prog++;
      chk(wren_seen, "R5 program frame preceded by write enable", wren_seen, 1);
      wren_seen = 1'b0;
      wel = 1'b0;
      c = calc_chunk(exp_off, exp_rem, cfg_pg);
      alen = cfg_a4 ? 4 : 3;
      chk(frame_len == 1 + alen + c, "R3 program frame length", frame_len, 1 + alen + c);
      chk(frame_len <= MSG, "R10 frame within message limit", frame_len, MSG);
      addr_ok = 1'b1;
      for (int i = 0; i < alen; i++)
        if (fr[1+i] != 8'(exp_off >> (8 * (alen - 1 - i)))) addr_ok = 1'b0;
      chk(addr_ok, "R6 address bytes MSB first", fr[1], 8'(exp_off >> (8 * (alen - 1))));
      data_ok = 1'b1;
      for (int k = 0; k < c; k++)
        if (1 + alen + k < frame_len && fr[1+alen+k] != strm[sidx+k]) data_ok = 1'b0;
      chk(data_ok, "R6 R9 data bytes in stream order", sidx, sidx);
      exp_off = exp_off + 32'(c);
      exp_rem = exp_rem - c;
      sidx    = sidx + c;
      busy_left = bpw;
    end else begin
      chk(1'b0, "R6 unknown frame opcode", fr[0], 2);
    end
  endtask

  // Device and stream model: drive at negedge, sample 1 ns later.
  always @(negedge clk) begin
    if (rst_n) begin
      link_ready_i = ($urandom % 4) != 0;
      in_valid_i   = (($urandom % 4) != 0) && (feed_idx < 1024);
      in_data_i    = strm[feed_idx % 1024];
      link_rdata_i = {6'b0, wel, busy_left > 0};
      #1;
      if (in_valid_i && in_ready_o) feed_idx++;
      if (link_valid_o && link_ready_i) begin
        if (frame_len < 128) fr[frame_len] = link_data_o;
        frame_len++;
        if (link_read_o && busy_left > 0) busy_left--;
        if (link_last_o) begin
          process_frame();
          frame_len = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [31:0] off, input int len, input int pg, input bit a4,
                     input int b, input bit wf, input int exp_err, input bit mid_start);
    int guard = 0;
    int n_exp;
    @(posedge clk); #1;
    for (int i = 0; i < 1024; i++) strm[i] = 8'($urandom);
    bpw = b; busy_left = b; wel = 1'b0; wel_block = wf; wren_seen = 1'b0;
    exp_off = off; exp_rem = len; sidx = 0; feed_idx = 0; n_prog = 0; n_stat = 0;
    frame_len = 0; cfg_pg = pg; cfg_a4 = a4;
    offset_i = off; len_i = LEN_W'(len); page_log2_i = PG_W'(pg); addr4_i = a4;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    while (guard < 60000) begin
      @(negedge clk); #2;
      guard++;
      if (mid_start && guard == 20) begin
        start_i = 1'b1; offset_i = ~off; len_i = LEN_W'(len + 7);
        page_log2_i = PG_W'(pg + 1); addr4_i = ~a4;
      end else if (mid_start && guard == 21) begin
        start_i = 1'b0;
      end
      if (done_o) break;
    end
    chk(done_o, "R7 done pulse seen", done_o, 1);
    chk(err_o == 2'(exp_err), "R7 R8 R5 error code", err_o, exp_err);
    n_exp = count_chunks(off, len, pg);
    if (exp_err == 0) begin
      chk(n_prog == n_exp, "R3 chunk count", n_prog, n_exp);
      chk(exp_rem == 0, "R3 all bytes programmed", exp_rem, 0);
      chk(feed_idx == len, "R9 stream bytes taken", feed_idx, len);
      chk(n_stat == (n_exp + 1) * (b + 1) + n_exp, "R4 status frame count",
          n_stat, (n_exp + 1) * (b + 1) + n_exp);
      if (mid_start) chk(n_prog == n_exp, "R11 start ignored while busy", n_prog, n_exp);
    end else begin
      chk(n_prog == 0, "R8 R5 no program frame after error", n_prog, 0);
      chk(feed_idx == 0, "R9 no stream byte taken on error", feed_idx, 0);
    end
    @(negedge clk); #2;
    chk(!busy_o && !done_o, "R7 back to idle after done", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    feed_idx = 0; frame_len = 0; busy_left = 0; wel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy_o && !done_o && !link_valid_o && !in_ready_o, "R1 reset state",
        {busy_o, done_o, link_valid_o, in_ready_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(!busy_o && !link_valid_o, "R1 idle after reset", link_valid_o, 0);

    // R2: large device page clamps to 64; offset 60 in page gives chunks 4 then 6
    run(32'h0000_003C, 10, 8, 1'b0, 1, 1'b0, 0, 1'b0);
    chk(n_prog == 2, "R2 clamped page gives two chunks", n_prog, 2);
    // R6: 4-byte address mode, 16-byte pages
    run(32'h0123_4567, 40, 4, 1'b1, 0, 1'b0, 0, 1'b0);
    // R3: one-byte page, every byte its own frame
    run(32'h00AB_CDEF, 5, 0, 1'b0, 0, 1'b0, 0, 1'b0);
    // R7: zero length only waits
    run(32'h0000_1000, 0, 8, 1'b0, 2, 1'b0, 0, 1'b0);
    // R8: PL-1 busy reads are fine, PL busy reads time out
    run(32'h0000_0100, 20, 8, 1'b0, PL - 1, 1'b0, 0, 1'b0);
    run(32'h0000_0100, 20, 8, 1'b0, PL, 1'b0, 1, 1'b0);
    // R5: write enable never latched
    run(32'h0000_0200, 20, 8, 1'b1, 1, 1'b1, 2, 1'b0);
    // R11: start pulse during an operation
    run(32'h0000_07F0, 50, 5, 1'b0, 1, 1'b0, 0, 1'b1);
    // random runs
    for (int t = 0; t < 12; t++) begin
      logic [31:0] o = $urandom;
      int l = 1 + ($urandom % 200);
      int p = $urandom % 11;
      bit a = 1'($urandom);
      int b = $urandom % 4;
      run(o, l, p, a, b, 1'b0, 0, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule